// File: doc/BRIEF.md
# RS-485 Half-Duplex Direction Controller

This block decides which way a half-duplex RS-485 transceiver points. It drives the transceiver's driver-enable and receiver-enable pins from one of two sources. In RTS mode the UART's request-to-send line sets the direction, so software turns the line around. In automatic mode the block watches the UART's serial output and a per-bit timing tick. It enables the driver when a character starts and releases the line at the end of the last stop bit. Software therefore never polls the UART for an empty shift register.

One 8-bit control register holds everything the block needs:

- the two mode enables;
- the character format (data length, parity, stop bits);
- a read-only flag that reports whether the RS-485 option is fitted.

For a full-duplex link, software selects RTS mode and holds RTS true, which keeps the driver on permanently.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control register reads 0x00 except bit 1, driver_en is 0 and receiver_en is 1.
- R2: With control bit 6 set and bit 7 clear, driver_en equals uart_rts and receiver_en equals its inverse in the same cycle, with no clock delay.
- R3: driver_en and receiver_en are never 1 together.
- R4: With both bit 7 and bit 6 set, automatic mode governs and uart_rts has no effect on either output.
- R5: With bits 7 and 6 both clear, driver_en is 0 and receiver_en is 1 whatever uart_rts does.
- R6: Control bit 1 reads OPTION_FITTED and bit 0 reads 0. Writes to these two bits are ignored. Bits 7..2 read back what was written.
- R7: In automatic mode (bit 7 set), a one-cycle tx_load pulse, or a high-to-low transition on uart_txd while the line is idle, sets driver_en at the next clock edge.
- R8: The frame length in bit ticks is 1 + (5 + bits[3:2]) + bit 4 + (1 + bit 5). Here bits[3:2] are the data-length code, bit 4 enables parity and bit 5 selects two stop bits. The format is captured when a character starts, so later writes do not change the frame in progress.
- R9: driver_en falls, and receiver_en rises, on the clock edge that takes the frame-length-th bit_tick after the start. bit_tick pulses that arrive while no frame is in progress have no effect.
- R10: A tx_load pulse during a frame restarts the full count, so back-to-back characters keep the driver on.
- R11: A falling uart_txd edge during the start or data/parity bits is ignored. A falling edge during the stop bits restarts the count.
- R12: Clearing bit 7 during a frame releases the driver at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read value |
| uart_rts | input | 1 | UART request-to-send, 1 = asserted |
| uart_txd | input | 1 | UART serial output, idle high |
| tx_load | input | 1 | One-cycle strobe marking a character start |
| bit_tick | input | 1 | One-cycle pulse at each bit-period boundary |
| driver_en | output | 1 | Transceiver driver enable, active high |
| receiver_en | output | 1 | Transceiver receiver enable, active high |

## Verification
The hardest situation to reach is a start edge that arrives while a frame is still counting. Whether it is accepted depends on where the count stands, inside the data bits or inside the stop window.

The bench counts ticks exactly. It places a uart_txd fall two ticks into a frame and checks that the fall is ignored. It places another fall after all but the last tick and checks that the fall restarts the frame. It also fires tx_load part-way through a frame and counts the remaining ticks to the exact release edge.

// File: rtl/rs485_pkg.sv
// Shared types for the RS-485 direction controller.
// Assumes: an 8-bit control register with fixed bit positions.
package rs485_pkg;

    // Which source currently sets the transceiver direction.
    typedef enum logic [1:0] {
        DIR_RX   = 2'd0,
        DIR_RTS  = 2'd1,
        DIR_AUTO = 2'd2
    } dir_mode_e;

    // Decoded fields of the control register.
    typedef struct packed {
        logic       auto_en;
        logic       rts_en;
        logic       two_stop;
        logic       par_en;
        logic [1:0] len_code;
    } ctrl_cfg_t;

    localparam int CTRL_W     = 8;
    localparam int BIT_AUTO   = 7;
    localparam int BIT_RTS    = 6;
    localparam int BIT_STOP2  = 5;
    localparam int BIT_PAR    = 4;
    localparam int BIT_LEN_HI = 3;
    localparam int BIT_LEN_LO = 2;
    localparam int BIT_OPT    = 1;

endpackage

// File: rtl/rs485_cfg_reg.sv
// Control/status register.
// Writes load bits 7..2. Bit 1 always reads the option-fitted strap and
// bit 0 always reads zero.
// Assumes: cfg_wr is a single-cycle strobe synchronous to clk.
module rs485_cfg_reg
    import rs485_pkg::*;
#(
    parameter logic OPTION_FITTED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] rdata,
    output ctrl_cfg_t         cfg
);

    localparam int STORE_W = CTRL_W - 2;

    logic [STORE_W-1:0] store_q;

    // Hold the writable upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            store_q <= '0;
        else if (wr)
            store_q <= wdata[CTRL_W-1:2];
    end

    // Assemble the read value and decode the fields.
    always_comb begin
        rdata          = {store_q, OPTION_FITTED, 1'b0};
        cfg.auto_en    = rdata[BIT_AUTO];
        cfg.rts_en     = rdata[BIT_RTS];
        cfg.two_stop   = rdata[BIT_STOP2];
        cfg.par_en     = rdata[BIT_PAR];
        cfg.len_code   = rdata[BIT_LEN_HI:BIT_LEN_LO];
    end

endmodule

// File: rtl/rs485_start_det.sv
// Character-start detector.
// Fires on a load strobe at any time. Also fires on a high-to-low uart_txd
// edge while no frame is active or while the active frame is in its stop
// bits, so falling edges inside the data bits are not taken as starts.
// Assumes: txd is synchronous to clk and idles high.
module rs485_start_det (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic txd,
    input  logic load,
    input  logic busy,
    input  logic in_stop,
    output logic start
);

    logic txd_q;

    // Remember the previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            txd_q <= 1'b1;
        else
            txd_q <= txd;
    end

    logic fall;

    // Qualify the edge and merge it with the load strobe.
    always_comb begin
        fall  = txd_q & ~txd;
        start = run & (load | (fall & (~busy | in_stop)));
    end

endmodule

// File: rtl/rs485_frame_timer.sv
// Bit-time counter for one character.
// Loads the frame length on start and counts bit ticks down. busy drops on
// the edge that takes the final tick.
// Assumes: tick is a one-cycle pulse; MAX_BITS covers the longest frame.
module rs485_frame_timer #(
    parameter int MIN_DATA = 5,
    parameter int MAX_BITS = 12,
    localparam int CNT_W   = $clog2(MAX_BITS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       start,
    input  logic       tick,
    input  logic [1:0] len_code,
    input  logic       par_en,
    input  logic       two_stop,
    output logic       busy,
    output logic       in_stop
);

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] stops_q;
    logic [CNT_W-1:0] frame_len;
    logic [CNT_W-1:0] stop_len;

    // Total bit count: start + data + parity + stop.
    always_comb begin
        stop_len  = CNT_W'(1) + CNT_W'(two_stop);
        frame_len = CNT_W'(1 + MIN_DATA) + CNT_W'(len_code)
                  + CNT_W'(par_en) + stop_len;
    end

    // Load on a start, count ticks, and drop busy on the final tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy     <= 1'b0;
            remain_q <= '0;
            stops_q  <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            remain_q <= frame_len;
            stops_q  <= stop_len;
        end else if (busy && tick) begin
            if (remain_q == CNT_W'(1)) begin
                busy     <= 1'b0;
                remain_q <= '0;
            end else begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // True while the remaining ticks lie inside the stop bits.
    always_comb begin
        in_stop = busy && (remain_q <= stops_q);
    end

endmodule

// File: rtl/rs485_dir_mux.sv
// Direction selector.
// Automatic mode outranks RTS mode. With neither mode set, the transceiver
// listens.
// Assumes: busy comes from the frame timer and rts is active high.
module rs485_dir_mux
    import rs485_pkg::*;
(
    input  logic auto_en,
    input  logic rts_en,
    input  logic busy,
    input  logic rts,
    output logic drv_en,
    output logic rcv_en
);

    dir_mode_e mode;

    // Pick the mode and derive both enables from it.
    always_comb begin
        if (auto_en)
            mode = DIR_AUTO;
        else if (rts_en)
            mode = DIR_RTS;
        else
            mode = DIR_RX;

        unique case (mode)
            DIR_AUTO: begin drv_en = busy;  rcv_en = ~busy; end
            DIR_RTS:  begin drv_en = rts;   rcv_en = ~rts;  end
            default:  begin drv_en = 1'b0;  rcv_en = 1'b1;  end
        endcase
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
// Top of the RS-485 half-duplex direction controller.
// Joins the control register, the start detector, the frame timer and the
// direction selector.
// Assumes: every input is synchronous to clk.
module rs485_dir_ctrl
    import rs485_pkg::*;
#(
    parameter logic OPTION_FITTED = 1'b1,
    parameter int   MIN_DATA      = 5,
    parameter int   MAX_BITS      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output logic [CTRL_W-1:0] cfg_rdata,
    input  logic              uart_rts,
    input  logic              uart_txd,
    input  logic              tx_load,
    input  logic              bit_tick,
    output logic              driver_en,
    output logic              receiver_en
);

    ctrl_cfg_t cfg;
    logic      auto_on;
    logic      rts_on;
    logic      busy;
    logic      in_stop;
    logic      start;

    rs485_cfg_reg #(
        .OPTION_FITTED(OPTION_FITTED)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    // Split out the mode enables for the timer, the selector and the checker.
    always_comb begin
        auto_on = cfg.auto_en;
        rts_on  = cfg.rts_en;
    end

    rs485_start_det u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (auto_on),
        .txd     (uart_txd),
        .load    (tx_load),
        .busy    (busy),
        .in_stop (in_stop),
        .start   (start)
    );

    rs485_frame_timer #(
        .MIN_DATA(MIN_DATA),
        .MAX_BITS(MAX_BITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (auto_on),
        .start    (start),
        .tick     (bit_tick),
        .len_code (cfg.len_code),
        .par_en   (cfg.par_en),
        .two_stop (cfg.two_stop),
        .busy     (busy),
        .in_stop  (in_stop)
    );

    rs485_dir_mux u_mux (
        .auto_en (auto_on),
        .rts_en  (rts_on),
        .busy    (busy),
        .rts     (uart_rts),
        .drv_en  (driver_en),
        .rcv_en  (receiver_en)
    );

endmodule

// File: rtl/rs485_dir_chk.sv
// Assertion checker for rs485_dir_ctrl, attached to it with bind.
// Assumes: auto_on and rts_on are the decoded mode bits inside the top.
module rs485_dir_chk #(
    parameter logic OPTION_FITTED = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_rdata,
    input logic       uart_rts,
    input logic       tx_load,
    input logic       bit_tick,
    input logic       driver_en,
    input logic       receiver_en,
    input logic       auto_on,
    input logic       rts_on
);

    assert_rts_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rts_on && !auto_on) |-> (driver_en == uart_rts && receiver_en == !uart_rts));

    assert_never_both_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(driver_en && receiver_en));

    assert_idle_listen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_on && !rts_on) |-> (!driver_en && receiver_en));

    assert_opt_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] == OPTION_FITTED) && !cfg_rdata[0]);

    assert_load_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && tx_load && !cfg_wr) |=> driver_en);

    assert_drop_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && $past(auto_on) && $fell(driver_en)) |-> $past(bit_tick));

endmodule

bind rs485_dir_ctrl rs485_dir_chk #(.OPTION_FITTED(OPTION_FITTED)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr      (cfg_wr),
    .cfg_rdata   (cfg_rdata),
    .uart_rts    (uart_rts),
    .tx_load     (tx_load),
    .bit_tick    (bit_tick),
    .driver_en   (driver_en),
    .receiver_en (receiver_en),
    .auto_on     (auto_on),
    .rts_on      (rts_on)
);

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       uart_rts = 1'b0;
    logic       uart_txd = 1'b1;
    logic       tx_load = 1'b0;
    logic       bit_tick = 1'b0;
    logic       driver_en;
    logic       receiver_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    rs485_dir_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .uart_rts    (uart_rts),
        .uart_txd    (uart_txd),
        .tx_load     (tx_load),
        .bit_tick    (bit_tick),
        .driver_en   (driver_en),
        .receiver_en (receiver_en)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Both enables in one value: {driver_en, receiver_en}.
    task automatic check_dir(input string req, input logic de);
        check(req, {6'd0, driver_en, receiver_en}, {6'd0, de, !de});
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk); tx_load = 1'b1;
        @(negedge clk); tx_load = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic txd_fall();
        @(negedge clk); uart_txd = 1'b0;
        @(negedge clk);
    endtask

    task automatic txd_rise();
        @(negedge clk); uart_txd = 1'b1;
        @(negedge clk);
    endtask

    // Run one frame started by tx_load and check the exact release tick.
    task automatic run_frame(input string req, input logic [7:0] cfgv, input int len);
        write_cfg(cfgv);
        pulse_load();
        check_dir({req, " start"}, 1'b1);
        ticks(len - 1);
        check_dir({req, " held"}, 1'b1);
        ticks(1);
        check_dir({req, " release"}, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 rdata", cfg_rdata, 8'h02);
        check_dir("R1 dir", 1'b0);
    endtask

    task automatic t_register();
        write_cfg(8'hFF);
        check("R6 write ones", cfg_rdata, 8'hFE);
        write_cfg(8'h03);
        check("R6 low bits ignored", cfg_rdata, 8'h02);
        write_cfg(8'h00);
    endtask

    task automatic t_rts_mode();
        write_cfg(8'h40);
        @(negedge clk); uart_rts = 1'b1; #1;
        check_dir("R2 rts high", 1'b1);
        @(negedge clk); uart_rts = 1'b0; #1;
        check_dir("R2 rts low", 1'b0);
    endtask

    task automatic t_no_mode();
        write_cfg(8'h00);
        @(negedge clk); uart_rts = 1'b1; #1;
        check_dir("R5 rts ignored", 1'b0);
        uart_rts = 1'b0;
    endtask

    task automatic t_priority();
        write_cfg(8'hC0);
        @(negedge clk); uart_rts = 1'b1; #1;
        check_dir("R4 rts has no effect", 1'b0);
        uart_rts = 1'b0;
        pulse_load();
        check_dir("R4 auto governs", 1'b1);
        ticks(7);
        check_dir("R4 release", 1'b0);
    endtask

    task automatic t_formats();
        run_frame("R8 len7", 8'h80, 7);   // 5 data, no parity, 1 stop
        run_frame("R8 len12", 8'hBC, 12); // 8 data, parity, 2 stop
        run_frame("R9 len9", 8'h94, 9);   // 6 data, parity, 1 stop
    endtask

    task automatic t_idle_ticks();
        write_cfg(8'h80);
        ticks(3);
        check_dir("R9 idle ticks", 1'b0);
    endtask

    task automatic t_txd_start();
        write_cfg(8'h8C);                 // 8 data, 1 stop -> 10
        txd_fall();
        check_dir("R7 txd fall starts", 1'b1);
        ticks(9);
        txd_rise();
        check_dir("R7 held", 1'b1);
        ticks(1);
        check_dir("R7 release", 1'b0);
    endtask

    task automatic t_retrigger();
        write_cfg(8'h80);
        pulse_load();
        ticks(5);
        pulse_load();
        ticks(6);
        check_dir("R10 still on after restart", 1'b1);
        ticks(1);
        check_dir("R10 release", 1'b0);
    endtask

    task automatic t_data_fall();
        write_cfg(8'h80);
        txd_fall();
        ticks(2);
        txd_rise();
        txd_fall();
        ticks(4);
        check_dir("R11 data fall ignored held", 1'b1);
        ticks(1);
        check_dir("R11 data fall ignored release", 1'b0);
        txd_rise();
        txd_fall();
        ticks(6);
        txd_rise();
        txd_fall();
        ticks(6);
        check_dir("R11 stop fall restarts", 1'b1);
        ticks(1);
        check_dir("R11 stop fall release", 1'b0);
        txd_rise();
    endtask

    task automatic t_format_latch();
        write_cfg(8'h80);
        pulse_load();
        write_cfg(8'hBC);
        ticks(7);
        check_dir("R8 format latched", 1'b0);
    endtask

    task automatic t_leave_auto();
        write_cfg(8'h80);
        pulse_load();
        ticks(2);
        write_cfg(8'h00);
        check_dir("R12 leave auto", 1'b0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_rts_mode();
        t_no_mode();
        t_priority();
        t_formats();
        t_idle_ticks();
        t_txd_start();
        t_retrigger();
        t_data_fall();
        t_format_latch();
        t_leave_auto();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule